// File: doc/BRIEF.md
# Key Event Queue with Pending Count

This block buffers the event bytes produced by a keypad scanner and by general-purpose input change detection until the host gets round to reading them. Each byte carries a 7-bit event code in bits 6:0 and a press/release flag in bit 7. The block stores the byte exactly as written and never interprets it. Key events and input events share one queue of ten entries and come out in arrival order.

The host sees the oldest pending byte on a combinational output at all times. A one-cycle read strobe removes that byte. A count output tells the host how many events are still waiting, and a flag shows that the queue is not empty. When an event arrives and all ten slots are full, the oldest event is thrown away and the new one takes its place. A sticky overflow flag is then raised, and it stays up until the host clears it.

Top module: `key_event_queue`

## Requirements
- R1: While reset is held and right after it is released, `pending` is 0, `has_event` is 0, `ovf_irq` is 0 and `head_byte` is 0x00.
- R2: Bytes leave the queue in the order they were written, and all 8 bits are unchanged. Bit 7 (press/release) is kept together with the code in bits 6:0.
- R3: `pending` equals the number of stored events and never exceeds 10. A write with no read raises it by one when it is below 10. A read with no write lowers it by one when it is above 0.
- R4: A write with no read while 10 events are stored discards the oldest event and appends the new one. `pending` stays at 10, and `head_byte` then shows the event that had been second oldest.
- R5: A write with no read into a full queue sets `ovf_irq` on the next cycle. The flag stays set until a cycle with `ovf_clr` high and no new overflow. If an overflow and `ovf_clr` happen in the same cycle, the flag stays set.
- R6: A read strobe while the queue is empty has no effect: `head_byte` reads 0x00 and `pending` stays 0.
- R7: A read and a write in the same cycle on a non-empty queue, full included, leave `pending` unchanged and do not set `ovf_irq`. The popped byte is the oldest one present before the write. On an empty queue the read is ignored and the write is stored.
- R8: `has_event` is 1 exactly when `pending` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_push | input | 1 | Write strobe for one event byte |
| ev_byte | input | 8 | Event byte to store: bit 7 press/release, bits 6:0 code |
| ev_pop | input | 1 | Read strobe; removes the oldest event |
| head_byte | output | 8 | Oldest pending event, 0x00 when empty |
| pending | output | 4 | Number of pending events, 0 to 10 |
| has_event | output | 1 | High when at least one event is pending |
| ovf_irq | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The hardest state to reach is a full queue whose pointers have already wrapped past slot nine more than once. In that state an overwrite, a simultaneous read and write, and an overflow clear all interact. The stimulus fills the queue, pushes several extra bytes to force repeated overwrites, and clears the flag both on its own and in the same cycle as a fresh overflow. It also issues paired reads and writes while the queue is full. A long pseudo-random phase follows, weighted towards writes, so that the queue keeps crossing the full boundary while a behavioural queue model is compared on every clock.

// File: rtl/key_event_queue.sv
module key_event_queue #(
  parameter int DEPTH = 10,
  parameter int BW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_push,
  input  logic [BW-1:0]                ev_byte,
  input  logic                         ev_pop,
  output logic [BW-1:0]                head_byte,
  output logic [$clog2(DEPTH+1)-1:0]   pending,
  output logic                         has_event,
  output logic                         ovf_irq,
  input  logic                         ovf_clr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [BW-1:0] slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  wire full     = (cnt == FULLC);
  wire empty    = (cnt == '0);
  wire take     = ev_pop && !empty;
  wire clobber  = ev_push && full && !take;
  wire grow     = ev_push && !take && !full;
  wire shrink   = take && !ev_push;

  always_ff @(posedge clk) begin
    if (ev_push) slots[wp] <= ev_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      ovf_irq <= 1'b0;
    end else begin
      if (ev_push) wp <= step_ptr(wp);
      if (take || clobber) rp <= step_ptr(rp);
      if (grow) cnt <= cnt + CW'(1);
      else if (shrink) cnt <= cnt - CW'(1);
      if (clobber) ovf_irq <= 1'b1;
      else if (ovf_clr) ovf_irq <= 1'b0;
    end
  end

  assign head_byte = empty ? '0 : slots[rp];
  assign pending   = cnt;
  assign has_event = !empty;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= FULLC);

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && !ev_pop && pending == FULLC) |=> (pending == FULLC));

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && !ev_pop && pending == FULLC) |=> ovf_irq);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && !ovf_clr) |=> ovf_irq);

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && !ev_push && pending == '0) |=> (pending == '0 && head_byte == '0));

  // R7
  pair_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && ev_push && pending != '0) |=> $stable(pending));
endmodule

// File: tb/sim_key_event_queue.sv
module sim_key_event_queue;
  localparam int DEPTH = 10;
  logic clk = 0, rst_n = 0;
  logic ev_push = 0, ev_pop = 0, ovf_clr = 0;
  logic [7:0] ev_byte = 0;
  logic [7:0] head_byte;
  logic [3:0] pending;
  logic has_event, ovf_irq;

  always #2.5 clk = ~clk;

  key_event_queue #(.DEPTH(DEPTH), .BW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_push(ev_push), .ev_byte(ev_byte),
    .ev_pop(ev_pop), .head_byte(head_byte), .pending(pending),
    .has_event(has_event), .ovf_irq(ovf_irq), .ovf_clr(ovf_clr));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mq [$];
  bit m_ovf = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_head;
    exp_head = (mq.size() == 0) ? 0 : int'(mq[0]);
    chk({tag, "/R2 head_byte"}, int'(head_byte), exp_head);
    chk({tag, "/R3 pending"}, int'(pending), mq.size());
    chk({tag, "/R8 has_event"}, int'(has_event), int'(mq.size() != 0));
    chk({tag, "/R5 ovf_irq"}, int'(ovf_irq), int'(m_ovf));
  endtask

  task automatic step(bit w, logic [7:0] d, bit r, bit c);
    @(negedge clk);
    compare_all();
    ev_push = w; ev_byte = d; ev_pop = r; ovf_clr = c;
    if (r && mq.size() > 0) void'(mq.pop_front());
    if (c) m_ovf = 0;
    if (w) begin
      if (mq.size() == DEPTH) begin
        void'(mq.pop_front());
        m_ovf = 1;
      end
      mq.push_back(d);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk("R1 pending in reset", int'(pending), 0);
    chk("R1 ovf in reset", int'(ovf_irq), 0);
    chk("R1 head in reset", int'(head_byte), 0);
    rst_n = 1;
    step(0, 0, 0, 0);
    tag = "R2";
    step(1, 8'h81, 0, 0);
    step(1, 8'h05, 0, 0);
    step(1, 8'hD0, 0, 0);
    step(1, 8'h7F, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0);
    tag = "R6";
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    @(negedge clk);
    chk("R6 empty read head 0x00", int'(head_byte), 0);
    chk("R6 empty read count 0", int'(pending), 0);
    tag = "R7";
    step(1, 8'h33, 1, 0);
    step(1, 8'h44, 1, 0);
    step(0, 0, 1, 0);
    tag = "R3";
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h10 + i), 0, 0);
    step(0, 0, 0, 0);
    chk("R3 full count", int'(pending), DEPTH);
    tag = "R4";
    step(1, 8'hA0, 0, 0);
    step(1, 8'hA1, 0, 0);
    step(0, 0, 0, 0);
    chk("R4 head after two overwrites", int'(head_byte), 8'h12);
    chk("R4 count saturates", int'(pending), DEPTH);
    tag = "R7";
    step(1, 8'hB0, 1, 0);
    step(0, 0, 0, 0);
    chk("R7 pair on full keeps count", int'(pending), DEPTH);
    tag = "R5";
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk("R5 cleared", int'(ovf_irq), 0);
    step(1, 8'hC0, 0, 1);
    step(0, 0, 0, 0);
    chk("R5 set wins over clear", int'(ovf_irq), 1);
    step(0, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0);
    tag = "R2";
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0] > 2, lfsr[15:8], lfsr[5:3] > 4, lfsr[9:6] == 0);
    end
    step(0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule